// File: doc/BRIEF.md
# Byte-Granular Dirty Cache with Dead-Stack Discard

This block is a small direct-mapped write-back data cache placed between a processor load/store port and a line-wide memory port. Instead of a single modified flag per line, every cached byte has its own dirty bit. When a line is evicted, only the bytes that were actually written reach memory, and a line whose mask has no bit set causes no memory write at all.

Software, or a compiler-inserted hint, can send a discard command carrying the new stack pointer after a function returns. The bytes below that pointer, down to the enclosing page boundary, are dead frame contents. The cache walks its indices one per clock and clears the dirty bits of every cached byte that falls inside that region, so that pending writebacks of dead data are cancelled. Data stays readable; only the obligation to write it back is dropped. A parameter can reduce the cleared region so that it reaches only down to the enclosing line boundary.

Two configuration inputs mark an address window as stack. A store that misses inside that window claims the line without reading it from memory, because the rest of a fresh frame holds nothing worth keeping. All other misses read the line in first.

Top module: `bdc_cache`

## Requirements
- R1: After reset every line is invalid and clean: busy, cpu_ack and mem_req are low, and the first load to any address issues exactly one line read.
- R2: A CPU access is a 32-bit word at cpu_addr with the low two address bits ignored. Byte k of the word (bits 8k+7:8k) belongs to address word_base+k and is written only when cpu_be[k] is set. A hit is acknowledged by a one-cycle cpu_ack pulse with no memory traffic, and a load returns the merged current bytes.
- R3: On eviction of a line with any dirty byte, one memory write is issued with mem_addr equal to the old line base address, the full line on mem_wdata, and mem_be equal to the dirty mask. Bit i of mem_be and bits 8i+7:8i of mem_wdata/mem_rdata belong to byte line_base+i.
- R4: Evicting a line with an all-zero dirty mask issues no memory write.
- R5: A store that misses with stk_base <= cpu_addr < stk_limit allocates the line with no memory read; bytes of that line not yet stored read as zero.
- R6: A store miss outside the stack window, and every load miss, first reads the line from memory and then applies the access.
- R7: A discard with pointer SP clears the dirty bit of every cached byte whose address A satisfies floor(SP, 4096) <= A < SP; bytes at or above SP keep their dirty bits, and cached data is unchanged.
- R8: Dirty bytes of cached lines whose addresses lie outside the discard range keep their dirty bits.
- R9: A discard accepted in an idle cycle has priority over a waiting CPU request; busy is then high for exactly NUM_LINES cycles, during which no cpu_ack and no memory request occur.
- R10: mem_req stays high with mem_addr and mem_we unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| stk_base | input | ADDR_W | Lowest address of the stack window |
| stk_limit | input | ADDR_W | First address above the stack window |
| dsc_valid | input | 1 | Discard command strobe |
| dsc_sp | input | ADDR_W | Stack pointer carried by the discard |
| busy | output | 1 | Discard walk in progress |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for line write, 0 for line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_BYTES*8 | Line write data |
| mem_be | output | LINE_BYTES | Byte enables of a line write |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | LINE_BYTES*8 | Line read data, valid with mem_ack |

## Verification
The bench builds the block with its defaults: a 16-bit address, 32-byte lines, eight lines and page-wide clearing, so a 256-byte cache span makes conflicting addresses easy to pick and every index is reached by the discard walk. With these values a single discard pointer places one line partly below and partly above it, a line fully inside the dead region, a line above it and a dirty line in another page all at once, and every byte-enable pattern of a word can be swept on one hit line.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2,
    ST_DISC = 2'd3
  } bdc_state_e;
endpackage

// File: rtl/bdc_merge.sv
module bdc_merge #(
  parameter int LINE_BYTES = 32
) (
  input  logic [LINE_BYTES*8-1:0]         line_i,
  input  logic [31:0]                     wdata,
  input  logic [3:0]                      be,
  input  logic [$clog2(LINE_BYTES)-3:0]   woff,
  output logic [LINE_BYTES*8-1:0]         line_o,
  output logic [LINE_BYTES-1:0]           bmask
);
  localparam int WORDS = LINE_BYTES / 4;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar k = 0; k < 4; k++) begin : g_byte
      logic sel;
      assign sel = (woff == w) && be[k];
      assign bmask[w*4+k] = sel;
      assign line_o[(w*4+k)*8 +: 8] = sel ? wdata[k*8 +: 8] : line_i[(w*4+k)*8 +: 8];
    end
  end
endmodule

// File: rtl/bdc_dead_mask.sv
module bdc_dead_mask #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32
) (
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] line_hi,
  input  logic [ADDR_W-1:0]                    lo,
  input  logic [ADDR_W-1:0]                    hi,
  output logic [LINE_BYTES-1:0]                kill
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic [ADDR_W-1:0] a;
    assign a = {line_hi, OFF_W'(b)};
    assign kill[b] = (a >= lo) && (a < hi);
  end
endmodule

// File: rtl/bdc_cache.sv
module bdc_cache
  import bdc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int LINE_BYTES    = 32,
  parameter int NUM_LINES     = 8,
  parameter int PAGE_BYTES    = 4096,
  parameter bit CLEAR_TO_PAGE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [31:0]             cpu_wdata,
  input  logic [3:0]              cpu_be,
  output logic                    cpu_ack,
  output logic [31:0]             cpu_rdata,
  input  logic [ADDR_W-1:0]       stk_base,
  input  logic [ADDR_W-1:0]       stk_limit,
  input  logic                    dsc_valid,
  input  logic [ADDR_W-1:0]       dsc_sp,
  output logic                    busy,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  output logic [LINE_BYTES-1:0]   mem_be,
  input  logic                    mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int WOFF_W    = OFF_W - 2;
  localparam int LO_W      = CLEAR_TO_PAGE ? $clog2(PAGE_BYTES) : OFF_W;

  bdc_state_e             state_q, state_d;
  logic [NUM_LINES-1:0]   valid_q;
  logic [TAG_W-1:0]       tag_q   [NUM_LINES];
  logic [LINE_BYTES-1:0]  dirty_q [NUM_LINES];
  logic [LINE_BITS-1:0]   data_q  [NUM_LINES];
  logic                   ack_q;
  logic [31:0]            rdata_q;
  logic [IDX_W-1:0]       walk_q, walk_d;
  logic [ADDR_W-1:0]      sp_q, lo_q;

  logic [IDX_W-1:0]       cpu_idx;
  logic [TAG_W-1:0]       cpu_tag;
  logic [WOFF_W-1:0]      cpu_woff;
  logic                   hit, in_stack, take, victim_dirty;
  logic                   do_hit, do_alloc, do_fill, do_wbdone, dsc_start;
  logic [LINE_BITS-1:0]   merged;
  logic [LINE_BYTES-1:0]  wr_mask, kill;
  logic                   unused_addr_bits;

  assign unused_addr_bits = ^cpu_addr[1:0];
  assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_woff = cpu_addr[OFF_W-1:2];

  assign hit          = valid_q[cpu_idx] && (tag_q[cpu_idx] == cpu_tag);
  assign in_stack     = (cpu_addr >= stk_base) && (cpu_addr < stk_limit);
  assign take         = cpu_req && !ack_q;
  assign victim_dirty = valid_q[cpu_idx] && (|dirty_q[cpu_idx]);

  assign dsc_start = (state_q == ST_IDLE) && dsc_valid;
  assign do_hit    = (state_q == ST_IDLE) && !dsc_valid && take && hit;
  assign do_alloc  = (state_q == ST_IDLE) && !dsc_valid && take && !hit &&
                     !victim_dirty && cpu_we && in_stack;
  assign do_fill   = (state_q == ST_FILL) && mem_ack;
  assign do_wbdone = (state_q == ST_WB) && mem_ack;

  bdc_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .line_i (data_q[cpu_idx]),
    .wdata  (cpu_wdata),
    .be     (cpu_be),
    .woff   (cpu_woff),
    .line_o (merged),
    .bmask  (wr_mask)
  );

  bdc_dead_mask #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_dead (
    .line_hi ({tag_q[walk_q], walk_q}),
    .lo      (lo_q),
    .hi      (sp_q),
    .kill    (kill)
  );

  // next state
  always_comb begin
    state_d = state_q;
    walk_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (dsc_valid) begin
          state_d = ST_DISC;
        end else if (take && !hit) begin
          if (victim_dirty)              state_d = ST_WB;
          else if (!(cpu_we && in_stack)) state_d = ST_FILL;
        end
      end
      ST_WB:   if (mem_ack) state_d = ST_IDLE;
      ST_FILL: if (mem_ack) state_d = ST_IDLE;
      ST_DISC: begin
        walk_d = walk_q + 1'b1;
        if (walk_q == IDX_W'(NUM_LINES-1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control and state bits with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= '0;
      ack_q   <= 1'b0;
      walk_q  <= '0;
      for (int i = 0; i < NUM_LINES; i++) dirty_q[i] <= '0;
    end else begin
      state_q <= state_d;
      walk_q  <= walk_d;
      ack_q   <= do_hit;
      if (do_hit && cpu_we) dirty_q[cpu_idx] <= dirty_q[cpu_idx] | wr_mask;
      if (do_alloc || do_fill) begin
        valid_q[cpu_idx] <= 1'b1;
        dirty_q[cpu_idx] <= '0;
      end
      if (do_wbdone) begin
        valid_q[cpu_idx] <= 1'b0;
        dirty_q[cpu_idx] <= '0;
      end
      if (state_q == ST_DISC) dirty_q[walk_q] <= dirty_q[walk_q] & ~kill;
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    if (do_hit) rdata_q <= data_q[cpu_idx][{cpu_woff, 5'b0} +: 32];
    if (do_hit && cpu_we) data_q[cpu_idx] <= merged;
    if (do_alloc) begin
      data_q[cpu_idx] <= '0;
      tag_q[cpu_idx]  <= cpu_tag;
    end
    if (do_fill) begin
      data_q[cpu_idx] <= mem_rdata;
      tag_q[cpu_idx]  <= cpu_tag;
    end
    if (dsc_start) begin
      sp_q <= dsc_sp;
      lo_q <= {dsc_sp[ADDR_W-1:LO_W], LO_W'(0)};
    end
  end

  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
  assign busy      = (state_q == ST_DISC);
  assign mem_req   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WB);
  assign mem_addr  = (state_q == ST_WB) ? {tag_q[cpu_idx], cpu_idx, OFF_W'(0)}
                                        : {cpu_tag, cpu_idx, OFF_W'(0)};
  assign mem_wdata = data_q[cpu_idx];
  assign mem_be    = (state_q == ST_WB) ? dirty_q[cpu_idx] : '0;
endmodule

// File: rtl/bdc_cache_chk.sv
module bdc_cache_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_ack,
  input logic                  busy,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [LINE_BYTES-1:0] mem_be,
  input logic                  mem_ack
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  p_wb_has_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != '0));

  p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cpu_ack);

  p_no_mem_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_req);

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);
endmodule

bind bdc_cache bdc_cache_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_ack  (cpu_ack),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .mem_ack  (mem_ack)
);

// File: tb/bdc_cache_tb.sv
module bdc_cache_tb;
  localparam int AW = 16;
  localparam int LB = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [31:0]   cpu_wdata;
  logic [3:0]    cpu_be;
  logic          cpu_ack;
  logic [31:0]   cpu_rdata;
  logic [AW-1:0] stk_base, stk_limit, dsc_sp;
  logic          dsc_valid, busy;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [LB*8-1:0] mem_wdata, mem_rdata;
  logic [LB-1:0] mem_be;

  int total = 0, bad = 0;
  int n_rd = 0, n_wr = 0;
  logic [AW-1:0] last_wa;
  logic [LB-1:0] last_be;
  logic [7:0] mem_m [int];
  logic [7:0] ref_m [int];

  always #5 clk = ~clk;

  bdc_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .stk_base(stk_base), .stk_limit(stk_limit), .dsc_valid(dsc_valid), .dsc_sp(dsc_sp),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] init_b(input int a);
    return 8'(a ^ (a >> 8) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] rmem(input int a);
    return mem_m.exists(a) ? mem_m[a] : init_b(a);
  endfunction

  function automatic logic [31:0] exp_word(input int a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[k*8 +: 8] = ref_m.exists(a+k) ? ref_m[a+k] : init_b(a+k);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder: waits one cycle, checks the request stayed put, then acks
  initial begin
    logic pend;
    logic [AW-1:0] sa;
    logic sw;
    pend = 1'b0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (!pend) begin
          pend = 1'b1; sa = mem_addr; sw = mem_we;
        end else begin
          chk(mem_addr == sa && mem_we == sw, "R10 request held", 64'(mem_addr), 64'(sa));
          if (mem_we) begin
            for (int i = 0; i < LB; i++)
              if (mem_be[i]) mem_m[int'(mem_addr)+i] = mem_wdata[i*8 +: 8];
            n_wr++; last_wa = mem_addr; last_be = mem_be;
          end else begin
            for (int i = 0; i < LB; i++) mem_rdata[i*8 +: 8] = rmem(int'(mem_addr)+i);
            n_rd++;
          end
          mem_ack = 1'b1; pend = 1'b0;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] q);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    do @(negedge clk); while (!cpu_ack);
    q = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic st(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] q;
    for (int k = 0; k < 4; k++) if (be[k]) ref_m[int'({a[AW-1:2], 2'b00})+k] = d[k*8 +: 8];
    cpu_op(1'b1, a, d, be, q);
  endtask

  task automatic ld(input logic [AW-1:0] a, output logic [31:0] q);
    cpu_op(1'b0, a, 32'h0, 4'h0, q);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    int r0, w0, bcnt, early;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    dsc_valid = 1'b0; dsc_sp = '0; stk_base = 16'h8000; stk_limit = 16'h9000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cpu_ack && !mem_req, "R1 reset outputs", {busy, cpu_ack, mem_req}, 0);

    ld(16'h1000, q);
    chk(n_rd == 1, "R1 first load reads once", n_rd, 1);
    chk(q == exp_word(16'h1000), "R6 load fill data", q, exp_word(16'h1000));

    // R2 sweep of all byte-enable patterns on a hit word
    for (int be = 1; be < 16; be++) begin
      st(16'h1000, {4{8'(be * 17)}}, 4'(be));
      ld(16'h1002, q);
      chk(q == exp_word(16'h1000), "R2 merged hit data", q, exp_word(16'h1000));
    end
    chk(n_rd == 1 && n_wr == 0, "R2 hits make no traffic", {n_rd, n_wr}, 64'h1_00000000);

    // store miss outside stack: writeback of dirty bytes 0..3, then fill
    r0 = n_rd;
    st(16'h2004, 32'hA1B2C3D4, 4'hF);
    chk(n_wr == 1 && last_wa == 16'h1000, "R3 writeback address", last_wa, 16'h1000);
    chk(last_be == 32'h0000000F, "R3 writeback mask", last_be, 32'hF);
    chk(rmem(16'h1000) == ref_m[16'h1000] && rmem(16'h1004) == init_b(16'h1004),
        "R3 memory bytes", rmem(16'h1000), ref_m[16'h1000]);
    chk(n_rd == r0 + 1, "R6 store miss fills", n_rd, r0 + 1);
    ld(16'h2000, q);
    chk(q == exp_word(16'h2000), "R6 unwritten fill bytes", q, exp_word(16'h2000));
    ld(16'h2004, q);
    chk(q == 32'hA1B2C3D4, "R6 stored word after fill", q, 32'hA1B2C3D4);

    ld(16'h3000, q);
    chk(n_wr == 2 && last_be == 32'h000000F0, "R3 mask second word", last_be, 32'hF0);
    w0 = n_wr;
    ld(16'h1000, q);
    chk(n_wr == w0, "R4 clean eviction no write", n_wr, w0);
    chk(q == exp_word(16'h1000), "R3 data survives round trip", q, exp_word(16'h1000));

    // stack allocation without fill
    r0 = n_rd;
    st(16'h8F40, 32'h11223344, 4'hF);
    chk(n_rd == r0, "R5 stack store no read", n_rd, r0);
    ld(16'h8F44, q);
    chk(q == 32'h0, "R5 unwritten bytes zero", q, 0);
    st(16'h8F48, 32'h55667788, 4'hF);
    st(16'h8F20, 32'h99AABBCC, 4'hF);
    st(16'h8F60, 32'hDDEEFF00, 4'hF);
    chk(n_rd == r0, "R5 further stack stores no read", n_rd, r0);
    st(16'h1080, 32'h0BADF00D, 4'hF);

    // discard with a waiting load
    @(negedge clk);
    dsc_valid = 1'b1; dsc_sp = 16'h8F48;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h8F48; cpu_be = 4'h0;
    @(negedge clk);
    dsc_valid = 1'b0;
    bcnt = 0; early = 0;
    while (!cpu_ack) begin
      if (busy) bcnt++;
      if (busy && mem_req) early++;
      @(negedge clk);
    end
    q = cpu_rdata; cpu_req = 1'b0;
    chk(bcnt == 8, "R9 busy cycles", bcnt, 8);
    chk(early == 0 && !busy, "R9 ack only after walk", early, 0);
    chk(q == 32'h55667788, "R7 data kept after discard", q, 32'h55667788);

    w0 = n_wr;
    ld(16'h0020, q);
    chk(n_wr == w0, "R7 fully dead line not written", n_wr, w0);
    ld(16'h0040, q);
    chk(n_wr == w0 + 1 && last_wa == 16'h8F40, "R7 partial line address", last_wa, 16'h8F40);
    chk(last_be == 32'h00000F00, "R7 partial line mask", last_be, 32'hF00);
    chk(!mem_m.exists(16'h8F40) && !mem_m.exists(16'h8F20), "R7 dead bytes never written",
        mem_m.exists(16'h8F40), 0);
    ld(16'h0060, q);
    chk(last_wa == 16'h8F60 && last_be == 32'h0000000F, "R7 line above pointer kept", last_be, 32'hF);
    ld(16'h0080, q);
    chk(last_wa == 16'h1080 && last_be == 32'h0000000F, "R8 other page kept", last_be, 32'hF);
    chk(rmem(16'h1080) == 8'h0D, "R8 other page data", rmem(16'h1080), 8'h0D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule